// File: doc/BRIEF.md
# Missing-Energy Vector Pre-Summer

The block takes twelve jet-element transverse energies on every bunch tick and reduces them to one partial sum of scalar energy (ET) and two signed vector components (EX, EY). Each channel has a 3-bit azimuth-bin select. The select picks a signed cosine and sine coefficient from a small programmable table. Because of this, a board whose links carry bins in swapped positions can be fixed by changing the register settings, with no change to the logic.

Each channel's energy is multiplied by its two coefficients. The block then applies two thresholds: one on the scalar energy and one on the magnitude of each component. The surviving terms go through an adder tree at full precision. Rounding down to 1 GeV happens only once, on the final sums, so the result is the same however the channels are ordered. ET saturates at 4095 GeV, and EX/EY saturate symmetrically at ±4095 GeV. A sticky flag records that saturation has occurred. The results appear a fixed three ticks after the input, together with a valid strobe.

Top module: `vector_presum`

## Requirements
- R1: Channel n's EX term is its 10-bit unsigned ET (1 GeV per count) times the 12-bit signed Q1.11 cosine of the bin chosen by bits [3n+2:3n] of `bin_sel`, and its EY term uses the sine in the same way. The table has 8 entries and is written through `cfg_we`/`cfg_bin`/`cfg_cos`/`cfg_sin`. A write takes effect for inputs sampled on the following tick.
- R2: A channel whose ET is below `et_thr` contributes zero to all three sums.
- R3: An EX or EY term whose magnitude is below `comp_thr` quarter-GeV counts (`comp_thr`×512 in product units) contributes zero to that sum only.
- R4: EX and EY are summed at full product precision. The total is then floored to whole GeV by an arithmetic shift right of 11. Per-channel rounding is never applied.
- R5: `out_et` saturates at 4095.
- R6: `out_ex` and `out_ey` are 14-bit two's complement values, clipped to the range [-4095, +4095].
- R7: `out_ovf` is set on any valid tick whose result saturated. It stays set until reset.
- R8: `out_valid` rises exactly three rising clock edges after the edge that samples `in_valid` high, and the result for that input appears at the same moment.
- R9: While `rst` is high, `out_valid`, `out_et`, `out_ex`, `out_ey` and `out_ovf` are zero, and every coefficient is cleared.
- R10: Any permutation of the (ET, bin) pairs across channels gives identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input set is valid this tick |
| in_et | input | 120 | Twelve 10-bit energies, channel n at [10n+9:10n] |
| bin_sel | input | 36 | Twelve 3-bit azimuth-bin selects |
| et_thr | input | 10 | Scalar energy threshold (GeV) |
| comp_thr | input | 12 | Component threshold (0.25 GeV counts) |
| cfg_we | input | 1 | Coefficient table write enable |
| cfg_bin | input | 3 | Table entry to write |
| cfg_cos | input | 12 | Signed Q1.11 cosine |
| cfg_sin | input | 12 | Signed Q1.11 sine |
| out_valid | output | 1 | Result valid |
| out_et | output | 12 | Scalar energy sum (GeV) |
| out_ex | output | 14 | Signed EX sum (GeV) |
| out_ey | output | 14 | Signed EY sum (GeV) |
| out_ovf | output | 1 | Sticky saturation flag |

## Verification
The bench sends twelve elements of 1 GeV each with a coefficient of 783/2048. The correct total is 4 GeV. A design that rounds each channel to quarter-GeV before summing gives 3 GeV instead. It also sends a single small negative term, where the floor must give -1; rounding toward zero would give 0. Full-scale inputs with coefficients +2047 and -2048 check that the clip is symmetric and that the overflow flag is sticky. A design that clips the negative side to -4096, or clears the flag on the next clean tick, shows up here. The same (ET, bin) pairs are applied in reversed channel order, and both thresholds are tested exactly at their edges, to catch channel-dependent lookup and off-by-one comparisons.

// File: rtl/vps_pkg.sv
package vps_pkg;
  parameter int NCH    = 12;
  parameter int ET_W   = 10;
  parameter int COEF_W = 12;
  parameter int BIN_W  = 3;
  parameter int FRAC_W = 11;
  parameter int THR_W  = 12;
  parameter int OET_W  = 12;
  parameter int OV_W   = 14;
endpackage

// File: rtl/vps_coef_table.sv
module vps_coef_table #(
  parameter int NCH    = vps_pkg::NCH,
  parameter int BIN_W  = vps_pkg::BIN_W,
  parameter int COEF_W = vps_pkg::COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [BIN_W-1:0]         wr_bin,
  input  logic [COEF_W-1:0]        wr_cos,
  input  logic [COEF_W-1:0]        wr_sin,
  input  logic [NCH*BIN_W-1:0]     rd_bin,
  output logic [NCH*COEF_W-1:0]    rd_cos,
  output logic [NCH*COEF_W-1:0]    rd_sin
);
  localparam int NBINS = 1 << BIN_W;

  logic [COEF_W-1:0] cos_mem [NBINS];
  logic [COEF_W-1:0] sin_mem [NBINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBINS; b++) begin
        cos_mem[b] <= '0;
        sin_mem[b] <= '0;
      end
    end else if (wr_en) begin
      cos_mem[wr_bin] <= wr_cos;
      sin_mem[wr_bin] <= wr_sin;
    end
  end

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      rd_cos[ch*COEF_W +: COEF_W] = cos_mem[rd_bin[ch*BIN_W +: BIN_W]];
      rd_sin[ch*COEF_W +: COEF_W] = sin_mem[rd_bin[ch*BIN_W +: BIN_W]];
    end
  end

  // R1: a written entry holds the written coefficients
  p_coef_write_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cos_mem[$past(wr_bin)] == $past(wr_cos)) &&
              (sin_mem[$past(wr_bin)] == $past(wr_sin)));
endmodule

// File: rtl/vps_channel.sv
module vps_channel #(
  parameter int ET_W   = vps_pkg::ET_W,
  parameter int COEF_W = vps_pkg::COEF_W,
  parameter int THR_W  = vps_pkg::THR_W,
  parameter int FRAC_W = vps_pkg::FRAC_W,
  localparam int PROD_W = ET_W + COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ET_W-1:0]          et,
  input  logic [ET_W-1:0]          et_thr,
  input  logic [THR_W-1:0]         comp_thr,
  input  logic signed [COEF_W-1:0] coef_c,
  input  logic signed [COEF_W-1:0] coef_s,
  output logic [ET_W-1:0]          term_et,
  output logic signed [PROD_W-1:0] term_ex,
  output logic signed [PROD_W-1:0] term_ey
);
  logic signed [PROD_W-1:0] px, py;
  logic [PROD_W-1:0] ax, ay, thr_full;
  logic et_ok;

  always_comb begin
    px       = PROD_W'($signed({1'b0, et})) * PROD_W'(coef_c);
    py       = PROD_W'($signed({1'b0, et})) * PROD_W'(coef_s);
    ax       = px[PROD_W-1] ? PROD_W'(-px) : PROD_W'(px);
    ay       = py[PROD_W-1] ? PROD_W'(-py) : PROD_W'(py);
    thr_full = PROD_W'({comp_thr, {(FRAC_W-2){1'b0}}});
    et_ok    = (et >= et_thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      term_et <= '0;
      term_ex <= '0;
      term_ey <= '0;
    end else begin
      term_et <= et_ok ? et : '0;
      term_ex <= (et_ok && ax >= thr_full) ? px : '0;
      term_ey <= (et_ok && ay >= thr_full) ? py : '0;
    end
  end

  // R2: sub-threshold element yields nothing on any sum
  p_et_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (et < et_thr) |=> (term_et == '0 && term_ex == '0 && term_ey == '0));
  // R3: a surviving component is at least the component threshold
  p_comp_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (term_ex != '0) |-> ((term_ex[PROD_W-1] ? PROD_W'(-term_ex) : PROD_W'(term_ex))
                         >= PROD_W'({$past(comp_thr), {(FRAC_W-2){1'b0}}})));
endmodule

// File: rtl/vps_finish.sv
module vps_finish #(
  parameter int SUM_W  = 27,
  parameter int ESUM_W = 14,
  parameter int FRAC_W = vps_pkg::FRAC_W,
  parameter int OET_W  = vps_pkg::OET_W,
  parameter int OV_W   = vps_pkg::OV_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [ESUM_W-1:0]       sum_et,
  input  logic signed [SUM_W-1:0] sum_ex,
  input  logic signed [SUM_W-1:0] sum_ey,
  output logic                    out_valid,
  output logic [OET_W-1:0]        out_et,
  output logic signed [OV_W-1:0]  out_ex,
  output logic signed [OV_W-1:0]  out_ey,
  output logic                    out_ovf
);
  localparam int LIM = (1 << OET_W) - 1;
  localparam logic signed [SUM_W-1:0] VLIM = SUM_W'(LIM);

  logic signed [SUM_W-1:0] gx, gy;
  logic sat_e, sat_x, sat_y;

  always_comb begin
    gx    = sum_ex >>> FRAC_W;
    gy    = sum_ey >>> FRAC_W;
    sat_e = (sum_et > ESUM_W'(LIM));
    sat_x = (gx > VLIM) || (gx < -VLIM);
    sat_y = (gy > VLIM) || (gy < -VLIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_et    <= '0;
      out_ex    <= '0;
      out_ey    <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_et  <= sat_e ? OET_W'(LIM) : OET_W'(sum_et);
        out_ex  <= sat_x ? (gx[SUM_W-1] ? OV_W'(-VLIM) : OV_W'(VLIM)) : OV_W'(gx);
        out_ey  <= sat_y ? (gy[SUM_W-1] ? OV_W'(-VLIM) : OV_W'(VLIM)) : OV_W'(gy);
        out_ovf <= out_ovf | sat_e | sat_x | sat_y;
      end
    end
  end

  // R7: the overflow flag never clears outside reset
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    out_ovf |=> out_ovf);
  // R6: vector outputs stay within the symmetric clip
  p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ex <= OV_W'(LIM) && out_ex >= -OV_W'(LIM) &&
                   out_ey <= OV_W'(LIM) && out_ey >= -OV_W'(LIM)));
endmodule

// File: rtl/vector_presum.sv
module vector_presum #(
  parameter int NCH    = vps_pkg::NCH,
  parameter int ET_W   = vps_pkg::ET_W,
  parameter int COEF_W = vps_pkg::COEF_W,
  parameter int BIN_W  = vps_pkg::BIN_W,
  parameter int FRAC_W = vps_pkg::FRAC_W,
  parameter int THR_W  = vps_pkg::THR_W,
  parameter int OET_W  = vps_pkg::OET_W,
  parameter int OV_W   = vps_pkg::OV_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NCH*ET_W-1:0]     in_et,
  input  logic [NCH*BIN_W-1:0]    bin_sel,
  input  logic [ET_W-1:0]         et_thr,
  input  logic [THR_W-1:0]        comp_thr,
  input  logic                    cfg_we,
  input  logic [BIN_W-1:0]        cfg_bin,
  input  logic [COEF_W-1:0]       cfg_cos,
  input  logic [COEF_W-1:0]       cfg_sin,
  output logic                    out_valid,
  output logic [OET_W-1:0]        out_et,
  output logic signed [OV_W-1:0]  out_ex,
  output logic signed [OV_W-1:0]  out_ey,
  output logic                    out_ovf
);
  localparam int PROD_W = ET_W + COEF_W + 1;
  localparam int GROW   = $clog2(NCH);
  localparam int SUM_W  = PROD_W + GROW;
  localparam int ESUM_W = ET_W + GROW;

  logic [NCH*COEF_W-1:0] cos_bus, sin_bus;
  logic [NCH*ET_W-1:0]   t_et;
  logic [NCH*PROD_W-1:0] t_ex, t_ey;
  logic v1, v2;
  logic [ESUM_W-1:0]       acc_et, s_et;
  logic signed [SUM_W-1:0] acc_ex, acc_ey, s_ex, s_ey;

  vps_coef_table #(.NCH(NCH), .BIN_W(BIN_W), .COEF_W(COEF_W)) u_tab (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_bin(cfg_bin),
    .wr_cos(cfg_cos), .wr_sin(cfg_sin), .rd_bin(bin_sel),
    .rd_cos(cos_bus), .rd_sin(sin_bus));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    vps_channel #(.ET_W(ET_W), .COEF_W(COEF_W), .THR_W(THR_W), .FRAC_W(FRAC_W)) u_ch (
      .clk(clk), .rst(rst),
      .et(in_et[g*ET_W +: ET_W]), .et_thr(et_thr), .comp_thr(comp_thr),
      .coef_c(cos_bus[g*COEF_W +: COEF_W]), .coef_s(sin_bus[g*COEF_W +: COEF_W]),
      .term_et(t_et[g*ET_W +: ET_W]),
      .term_ex(t_ex[g*PROD_W +: PROD_W]), .term_ey(t_ey[g*PROD_W +: PROD_W]));
  end

  always_comb begin
    acc_et = '0;
    acc_ex = '0;
    acc_ey = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      acc_et = acc_et + ESUM_W'(t_et[ch*ET_W +: ET_W]);
      acc_ex = acc_ex + SUM_W'($signed(t_ex[ch*PROD_W +: PROD_W]));
      acc_ey = acc_ey + SUM_W'($signed(t_ey[ch*PROD_W +: PROD_W]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      v2   <= 1'b0;
      s_et <= '0;
      s_ex <= '0;
      s_ey <= '0;
    end else begin
      v1   <= in_valid;
      v2   <= v1;
      s_et <= acc_et;
      s_ex <= acc_ex;
      s_ey <= acc_ey;
    end
  end

  vps_finish #(.SUM_W(SUM_W), .ESUM_W(ESUM_W), .FRAC_W(FRAC_W),
               .OET_W(OET_W), .OV_W(OV_W)) u_fin (
    .clk(clk), .rst(rst), .in_valid(v2),
    .sum_et(s_et), .sum_ex(s_ex), .sum_ey(s_ey),
    .out_valid(out_valid), .out_et(out_et), .out_ex(out_ex),
    .out_ey(out_ey), .out_ovf(out_ovf));

  // R8: every result strobe traces back to an input three edges earlier
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));
endmodule

// File: tb/vector_presum_bench.sv
`timescale 1ns/1ps
module vector_presum_bench;
  localparam int NCH = 12;
  localparam int NV  = 6;
  // base, step, bin offset, et_thr, comp_thr
  localparam int VEC [NV][5] = '{
    '{ 10,  7, 0,   0,   0},
    '{300, 41, 3,  20,   4},
    '{ 50, 13, 5, 100,   0},
    '{900,  3, 1,   0, 200},
    '{  0, 90, 6, 400,  50},
    '{123, 77, 2,  60,  16}
  };
  localparam int COS_T [8] = '{1892, 783, -783, -1892, -1892, -783, 783, 1892};
  localparam int SIN_T [8] = '{783, 1892, 1892, 783, -783, -1892, -1892, -783};

  logic clk = 0, rst = 1, in_valid = 0, cfg_we = 0;
  logic [NCH*10-1:0] in_et = '0;
  logic [NCH*3-1:0] bin_sel = '0;
  logic [9:0] et_thr = '0;
  logic [11:0] comp_thr = '0;
  logic [2:0] cfg_bin = '0;
  logic [11:0] cfg_cos = '0, cfg_sin = '0;
  logic out_valid, out_ovf;
  logic [11:0] out_et;
  logic signed [13:0] out_ex, out_ey;

  int checks = 0, errors = 0;
  int et_a [NCH];
  int bin_a [NCH];
  int cos_m [8];
  int sin_m [8];
  bit exp_ovf = 0;
  longint ge, gx, gy;

  always #2.5 clk = ~clk;

  vector_presum u_vector_presum (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_et(in_et), .bin_sel(bin_sel),
    .et_thr(et_thr), .comp_thr(comp_thr), .cfg_we(cfg_we), .cfg_bin(cfg_bin),
    .cfg_cos(cfg_cos), .cfg_sin(cfg_sin), .out_valid(out_valid), .out_et(out_et),
    .out_ex(out_ex), .out_ey(out_ey), .out_ovf(out_ovf));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_coef(int b, int c, int s);
    cfg_bin = 3'(b); cfg_cos = 12'(c); cfg_sin = 12'(s); cfg_we = 1;
    cos_m[b] = c; sin_m[b] = s;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  function automatic longint clipv(longint v);
    if (v > 4095) return 4095;
    if (v < -4095) return -4095;
    return v;
  endfunction

  task automatic model(output longint ee, output longint ex, output longint ey);
    longint se = 0, sx = 0, sy = 0, px, py, th;
    th = longint'(comp_thr) * 512;
    for (int c = 0; c < NCH; c++) begin
      if (et_a[c] >= int'(et_thr)) begin
        se += et_a[c];
        px = longint'(et_a[c]) * cos_m[bin_a[c]];
        py = longint'(et_a[c]) * sin_m[bin_a[c]];
        if ((px < 0 ? -px : px) >= th) sx += px;
        if ((py < 0 ? -py : py) >= th) sy += py;
      end
    end
    sx = sx >>> 11;
    sy = sy >>> 11;
    if (se > 4095 || clipv(sx) != sx || clipv(sy) != sy) exp_ovf = 1;
    ee = (se > 4095) ? 4095 : se;
    ex = clipv(sx);
    ey = clipv(sy);
  endtask

  // drives one set, waits three edges, leaves results in ge/gx/gy
  task automatic run(string req);
    longint ee, ex, ey;
    for (int c = 0; c < NCH; c++) begin
      in_et[c*10 +: 10] = 10'(et_a[c]);
      bin_sel[c*3 +: 3] = 3'(bin_a[c]);
    end
    model(ee, ex, ey);
    in_valid = 1;
    @(posedge clk); #1 in_valid = 0;
    @(posedge clk); @(posedge clk); #1;
    ge = longint'(out_et); gx = longint'(out_ex); gy = longint'(out_ey);
    chk({req, " valid"}, longint'(out_valid), 1);
    chk({req, " et"}, ge, ee);
    chk({req, " ex"}, gx, ex);
    chk({req, " ey"}, gy, ey);
    chk({req, " ovf R7"}, longint'(out_ovf), longint'(exp_ovf));
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint ax, ay, ae;
    for (int b = 0; b < 8; b++) begin cos_m[b] = 0; sin_m[b] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 valid", longint'(out_valid), 0);
    chk("R9 et", longint'(out_et), 0);
    chk("R9 ex", longint'(out_ex), 0);
    chk("R9 ovf", longint'(out_ovf), 0);
    rst = 0;
    @(posedge clk); #1;
    // R9: cleared table -> zero vector even with energy present
    for (int c = 0; c < NCH; c++) begin et_a[c] = 100; bin_a[c] = c % 8; end
    run("R9 cleared table");
    for (int b = 0; b < 8; b++) wr_coef(b, COS_T[b], SIN_T[b]);

    // R1 R2 R3 R4 table-driven vectors
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < NCH; c++) begin
        et_a[c]  = (VEC[v][0] + VEC[v][1] * c) % 1024;
        bin_a[c] = (c + VEC[v][2]) % 8;
      end
      et_thr = 10'(VEC[v][3]);
      comp_thr = 12'(VEC[v][4]);
      run("R1 vector");
    end
    et_thr = 0; comp_thr = 0;

    // R8 latency: not valid after two edges, valid after three
    for (int c = 0; c < NCH; c++) begin et_a[c] = 5; bin_a[c] = 0; end
    in_et = '0; for (int c = 0; c < NCH; c++) in_et[c*10 +: 10] = 10'd5;
    bin_sel = '0;
    in_valid = 1;
    @(posedge clk); #1 in_valid = 0;
    @(posedge clk); #1;
    chk("R8 early valid", longint'(out_valid), 0);
    @(posedge clk); #1;
    chk("R8 on-time valid", longint'(out_valid), 1);
    chk("R8 et", longint'(out_et), 60);

    // R4 full precision: 12 x (1 * 783) = 9396 -> 4 GeV, per-channel rounding gives 3
    for (int c = 0; c < NCH; c++) begin et_a[c] = 1; bin_a[c] = 1; end
    run("R4 full precision");
    chk("R4 ex total", gx, 4);
    // R4 floor of a small negative term: -783 -> -1
    for (int c = 0; c < NCH; c++) begin et_a[c] = 0; bin_a[c] = 0; end
    et_a[0] = 1; bin_a[0] = 2;
    run("R4 floor");
    chk("R4 negative floor", gx, -1);

    // R2 threshold edge: ET equal passes, one below is dropped
    for (int c = 0; c < NCH; c++) begin et_a[c] = 0; bin_a[c] = 0; end
    et_a[3] = 100; et_a[4] = 99; et_thr = 10'd100;
    run("R2 edge");
    chk("R2 et only equal", ge, 100);
    et_thr = 0;
    // R3 component edge: 1*1892 vs thr 4 (2048) drops EX, keeps EY? 783 < 2048 drops both
    for (int c = 0; c < NCH; c++) begin et_a[c] = 0; bin_a[c] = 0; end
    et_a[0] = 2; bin_a[0] = 1; comp_thr = 12'd7; // ex 1566 < 3584 drop, ey 3784 keep
    run("R3 edge");
    chk("R3 ex dropped", gx, 0);
    chk("R3 ey kept", gy, 1);
    chk("R3 et kept", ge, 2);
    comp_thr = 0;

    // R10 channel order independence
    for (int c = 0; c < NCH; c++) begin et_a[c] = 37 * c + 11; bin_a[c] = (3 * c) % 8; end
    run("R10 forward");
    ae = ge; ax = gx; ay = gy;
    for (int c = 0; c < NCH; c++) begin et_a[NCH-1-c] = 37 * c + 11; bin_a[NCH-1-c] = (3 * c) % 8; end
    run("R10 reversed");
    chk("R10 et match", ge, ae);
    chk("R10 ex match", gx, ax);
    chk("R10 ey match", gy, ay);

    // R1 R5 R6 R7 full scale with rewritten entry
    wr_coef(7, 2047, -2048);
    for (int c = 0; c < NCH; c++) begin et_a[c] = 1023; bin_a[c] = 7; end
    run("R5 R6 saturation");
    chk("R5 et clip", ge, 4095);
    chk("R6 ex clip", gx, 4095);
    chk("R6 ey clip", gy, -4095);
    chk("R7 ovf set", longint'(out_ovf), 1);
    // R7 sticky over a clean tick
    for (int c = 0; c < NCH; c++) begin et_a[c] = 3; bin_a[c] = 0; end
    run("R7 sticky");
    chk("R7 still set", longint'(out_ovf), 1);

    // R9 reset again clears flag
    rst = 1; @(posedge clk); #1 rst = 0; exp_ovf = 0;
    chk("R9 ovf cleared", longint'(out_ovf), 0);
    chk("R9 valid cleared", longint'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule